// File: doc/BRIEF.md
# Paged Memory Window Translator

This block sits between a 16-bit processor address bus and a wider external SRAM. It holds sixteen page registers, one per 4 KiB slice of the processor's 64 KiB space. The top nibble of each processor address picks a register and the low twelve bits pass through as the offset inside the page. With the default five stored page bits the external address is 17 bits wide, reaching 32 pages of 4 KiB.

Two control inputs steer it. The mode select picks flat pass-through or paged translation. Its value is sampled on each clock edge and is cleared by reset. The register-access enable turns the 0x4000 slice of the address space into a window onto the page registers, and flags that slice so the device ROM normally decoded there stays quiet. Software loads a page number into the high byte of a register word. A read returns the page in both bytes of the data word. Moving a page into view needs only one register write and copies no data.

Top module: `page_mapper`

## Requirements
- R1: A synchronous active-high reset clears all sixteen page registers to zero and selects pass-through mode.
- R2: In pass-through mode `mem_addr` equals `cpu_addr`, zero-extended, so the page bits above bit 15 read zero.
- R3: `map_sel` is sampled on every rising clock edge. The mode it selects governs `mem_addr` from the cycle after that edge.
- R4: In paged mode `mem_addr` is the page held by register `cpu_addr[15:12]`, followed by `cpu_addr[11:0]`. The top nibble of `cpu_addr` does not appear in the result.
- R5: A register keeps only the low `PAGE_W` (5) bits of the written high byte. Writing 0xF500 stores page 0x15 and reads back as 0x1515.
- R6: While `reg_access` is high, an access with `cpu_addr[15:12]` = 0x4 is a register access. Register n is selected by `cpu_addr[4:1]`, so it sits at 0x4000 + 2n, and `cpu_addr[11:5]` and bit 0 are ignored. A write with `cpu_wr` high stores `cpu_wdata[15:8]` on the rising clock edge.
- R7: With `reg_access` high, `cpu_rd` high and the address inside the 0x4000 slice, `cpu_rdata` is {page, page}: the zero-extended page byte appears in both bytes. In every other cycle `cpu_rdata` is zero.
- R8: `rom_disable` is high exactly when `reg_access` is high and `cpu_addr[15:12]` = 0x4.
- R9: A write while `reg_access` is low leaves every page register unchanged.
- R10: Two registers that hold the same page translate their slices to the same physical address for equal offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Processor byte address |
| cpu_wdata | input | 16 | Processor write data; the page is taken from the high byte |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe, acted on at the clock edge |
| map_sel | input | 1 | Mode select: 1 = paged, 0 = pass-through |
| reg_access | input | 1 | Exposes the page registers in the 0x4000 slice |
| mem_addr | output | 17 | Physical SRAM address |
| cpu_rdata | output | 16 | Register readback data |
| rom_disable | output | 1 | Suppresses device ROM in the 0x4000 slice |

## Verification
Register writes and translation can fall in the same cycle. In paged mode, a write to the window at 0x4008 also translates through register 4, the very register being written. The bench provokes this with a directed write of a new page to register 4 while paged mode and register access are both on, and it repeats the case many times in the random phase. During the write cycle `mem_addr` must show the old page and `cpu_rdata` the old value. From the next cycle both must show the new page.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  localparam int CPU_AW  = 16;
  localparam int CPU_DW  = 16;
  localparam int OFS_W   = 12;
  localparam int IDX_W   = CPU_AW - OFS_W;
  localparam int NREGS   = 1 << IDX_W;
  localparam int BYTE_W  = 8;

  typedef logic [CPU_AW-1:0] cpu_addr_t;
  typedef logic [IDX_W-1:0]  reg_idx_t;

  typedef struct packed {
    logic     hit;
    logic     wr;
    logic     rd;
    reg_idx_t idx;
  } win_dec_t;
endpackage

// File: rtl/pm_regfile.sv
module pm_regfile #(
  parameter int PAGE_W = 5,
  parameter int IDX_W  = 4,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [PAGE_W-1:0] wpage,
  input  logic [IDX_W-1:0]  xl_idx,
  output logic [PAGE_W-1:0] xl_page,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic [PAGE_W-1:0] rb_page
);
  logic [PAGE_W-1:0] pages [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) pages[i] <= '0;
    end else if (we) begin
      pages[widx] <= wpage;
    end
  end

  assign xl_page = pages[xl_idx];
  assign rb_page = pages[rb_idx];
endmodule

// File: rtl/pm_window.sv
module pm_window
  import mapper_pkg::*;
#(
  parameter logic [IDX_W-1:0] WIN_SLICE = 4'h4
) (
  input  cpu_addr_t cpu_addr,
  input  logic      cpu_rd,
  input  logic      cpu_wr,
  input  logic      reg_access,
  output win_dec_t  dec
);
  logic in_slice;

  assign in_slice = (cpu_addr[CPU_AW-1 -: IDX_W] == WIN_SLICE);

  always_comb begin
    dec.hit = reg_access && in_slice;
    dec.wr  = dec.hit && cpu_wr;
    dec.rd  = dec.hit && cpu_rd;
    dec.idx = cpu_addr[IDX_W:1];
  end
endmodule

// File: rtl/pm_xlate.sv
module pm_xlate
  import mapper_pkg::*;
#(
  parameter int PAGE_W = 5,
  localparam int PHYS_W = PAGE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              map_sel,
  input  cpu_addr_t         cpu_addr,
  input  logic [PAGE_W-1:0] page,
  output logic              mode_q,
  output logic [PHYS_W-1:0] mem_addr
);
  logic [PHYS_W-1:0] flat;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 1'b0;
    else     mode_q <= map_sel;
  end

  generate
    if (PHYS_W >= CPU_AW) begin : g_wide
      assign flat = {{(PHYS_W-CPU_AW){1'b0}}, cpu_addr};
    end else begin : g_narrow
      assign flat = cpu_addr[PHYS_W-1:0];
    end
  endgenerate

  assign mem_addr = mode_q ? {page, cpu_addr[OFS_W-1:0]} : flat;
endmodule

// File: rtl/page_mapper.sv
module page_mapper
  import mapper_pkg::*;
#(
  parameter int PAGE_W = 5,
  localparam int PHYS_W = PAGE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cpu_addr,
  input  logic [15:0]       cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic              map_sel,
  input  logic              reg_access,
  output logic [PHYS_W-1:0] mem_addr,
  output logic [15:0]       cpu_rdata,
  output logic              rom_disable
);
  win_dec_t          dec;
  logic [PAGE_W-1:0] xl_page;
  logic [PAGE_W-1:0] rb_page;
  logic [BYTE_W-1:0] rb_byte;
  logic              mode_q;

  pm_window u_win (
    .cpu_addr  (cpu_addr),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .reg_access(reg_access),
    .dec       (dec)
  );

  pm_regfile #(.PAGE_W(PAGE_W), .IDX_W(IDX_W)) u_rf (
    .clk    (clk),
    .rst    (rst),
    .we     (dec.wr),
    .widx   (dec.idx),
    .wpage  (cpu_wdata[CPU_DW-BYTE_W +: PAGE_W]),
    .xl_idx (cpu_addr[CPU_AW-1 -: IDX_W]),
    .xl_page(xl_page),
    .rb_idx (dec.idx),
    .rb_page(rb_page)
  );

  pm_xlate #(.PAGE_W(PAGE_W)) u_xl (
    .clk     (clk),
    .rst     (rst),
    .map_sel (map_sel),
    .cpu_addr(cpu_addr),
    .page    (xl_page),
    .mode_q  (mode_q),
    .mem_addr(mem_addr)
  );

  always_comb begin
    rb_byte = '0;
    rb_byte[PAGE_W-1:0] = rb_page;
  end

  assign cpu_rdata   = dec.rd ? {rb_byte, rb_byte} : '0;
  assign rom_disable = dec.hit;
endmodule

// File: rtl/pm_checker.sv
module pm_checker #(
  parameter int PHYS_W = 17
) (
  input logic              clk,
  input logic              rst,
  input logic [15:0]       cpu_addr,
  input logic              cpu_rd,
  input logic              reg_access,
  input logic              mode_q,
  input logic [PHYS_W-1:0] mem_addr,
  input logic [15:0]       cpu_rdata,
  input logic              rom_disable
);
  // R1
  reset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mem_addr[15:0] == cpu_addr && mem_addr[PHYS_W-1:16] == '0));

  // R2
  pass_flat_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_q |-> (mem_addr[15:0] == cpu_addr && mem_addr[PHYS_W-1:16] == '0));

  // R4
  offset_keep_chk: assert property (@(posedge clk) disable iff (rst)
    mem_addr[11:0] == cpu_addr[11:0]);

  // R7
  rdata_dup_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_rdata[15:8] == cpu_rdata[7:0]);

  // R7
  rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!reg_access || !cpu_rd) |-> (cpu_rdata == 16'h0000));

  // R8
  romdis_gate_chk: assert property (@(posedge clk) disable iff (rst)
    rom_disable |-> (reg_access && cpu_addr[15:12] == 4'h4));
endmodule

bind page_mapper pm_checker #(.PHYS_W(PHYS_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cpu_addr   (cpu_addr),
  .cpu_rd     (cpu_rd),
  .reg_access (reg_access),
  .mode_q     (mode_q),
  .mem_addr   (mem_addr),
  .cpu_rdata  (cpu_rdata),
  .rom_disable(rom_disable)
);

// File: tb/sim_page_mapper.sv
`timescale 1ns/1ps
module sim_page_mapper;
  localparam int PW = 5;
  localparam int AW = PW + 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [15:0]   cpu_addr = '0;
  logic [15:0]   cpu_wdata = '0;
  logic          cpu_rd = 1'b0;
  logic          cpu_wr = 1'b0;
  logic          map_sel = 1'b0;
  logic          reg_access = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [15:0]   cpu_rdata;
  logic          rom_disable;

  int n_chk = 0;
  int n_bad = 0;
  logic [PW-1:0] m_pg [16];
  logic          m_mode;

  always #2.5 clk = ~clk;

  page_mapper #(.PAGE_W(PW)) u0 (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .map_sel(map_sel),
    .reg_access(reg_access), .mem_addr(mem_addr), .cpu_rdata(cpu_rdata),
    .rom_disable(rom_disable)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(input logic [15:0] a);
    if (m_mode) return {m_pg[a[15:12]], a[11:0]};
    return {{(AW-16){1'b0}}, a};
  endfunction

  function automatic logic [15:0] exp_rdata(input logic [15:0] a, input logic rd, input logic acc);
    logic [7:0] b;
    b = '0;
    b[PW-1:0] = m_pg[a[4:1]];
    if (rd && acc && a[15:12] == 4'h4) return {b, b};
    return 16'h0000;
  endfunction

  // One bus cycle: drive at negedge, judge combinational outputs, then commit at posedge.
  task automatic cycle(input logic [15:0] a, input logic [15:0] d, input logic rd,
                       input logic wr, input logic acc, input logic ms);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_rd = rd; cpu_wr = wr;
    reg_access = acc; map_sel = ms;
    #1;
    chk(m_mode ? "R4 paged address" : "R2 flat address", 32'(mem_addr), 32'(exp_addr(a)));
    chk("R7 readback", 32'(cpu_rdata), 32'(exp_rdata(a, rd, acc)));
    chk("R8 rom disable", 32'(rom_disable), 32'(acc && a[15:12] == 4'h4));
    @(posedge clk);
    if (wr && acc && a[15:12] == 4'h4) m_pg[a[4:1]] = d[8 +: PW];
    m_mode = ms;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] a;
    logic [15:0] d;
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) m_pg[i] = '0;
    m_mode = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: registers cleared, flat mode after reset
    cycle(16'hA123, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R1 flat after reset", 32'(mem_addr), 32'h0A123);
    cycle(16'h4014, 16'h0, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R1 register zero after reset", 32'(cpu_rdata), 32'h0000);

    // R9: write without register access is ignored
    cycle(16'h4014, 16'h1F00, 1'b0, 1'b1, 1'b0, 1'b0);
    cycle(16'h4014, 16'h0, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R9 ignored write", 32'(cpu_rdata), 32'h0000);

    // R6: load every register, then read each back
    for (int i = 0; i < 16; i++) begin
      d = 16'(((i * 7 + 3) & 31) << 8);
      cycle(16'h4000 + 16'(2 * i), d, 1'b0, 1'b1, 1'b1, 1'b0);
    end
    for (int i = 0; i < 16; i++) begin
      cycle(16'h4000 + 16'(2 * i), 16'h0, 1'b1, 1'b0, 1'b1, 1'b0);
      d = 16'((i * 7 + 3) & 31);
      chk("R6 register loaded", 32'(cpu_rdata), 32'({d[7:0], d[7:0]}));
    end

    // R3: mode change takes effect one cycle after the sampling edge
    cycle(16'hC456, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R3 still flat in select cycle", 32'(mem_addr), 32'h0C456);
    cycle(16'hC456, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R3 paged after edge", 32'(mem_addr), 32'({5'((12 * 7 + 3) & 31), 12'h456}));

    // R4: translation through every register
    for (int i = 0; i < 16; i++) begin
      a = {4'(i), 12'h5A5};
      cycle(a, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1);
    end

    // R5: high page bits dropped
    cycle(16'h4016, 16'hF500, 1'b0, 1'b1, 1'b1, 1'b1);
    cycle(16'h4016, 16'h0, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R5 page alias readback", 32'(cpu_rdata), 32'h1515);

    // R10: two slices share one page
    cycle(16'h4014, 16'h1500, 1'b0, 1'b1, 1'b1, 1'b1);
    cycle(16'hA02E, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R10 slice A", 32'(mem_addr), 32'h1502E);
    cycle(16'hB02E, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R10 slice B", 32'(mem_addr), 32'h1502E);

    // Write and translate through the same register in one cycle
    cycle(16'h4008, 16'h0900, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R6 old page during write", 32'(mem_addr), 32'({5'((4 * 7 + 3) & 31), 12'h008}));
    cycle(16'h4008, 16'h0, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R6 new page after write", 32'(mem_addr), 32'h09008);

    // R3: back to flat, one cycle late
    cycle(16'hE001, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    cycle(16'hE001, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R3 flat again", 32'(mem_addr), 32'h0E001);

    // Random phase
    for (int k = 0; k < 3000; k++) begin
      a = 16'($urandom);
      if ($urandom_range(2) == 0) a[15:12] = 4'h4;
      cycle(a, 16'($urandom), 1'($urandom), 1'($urandom),
            ($urandom_range(3) != 0), 1'($urandom));
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule